// File: doc/BRIEF.md
# E3 Receive Alarm Interrupt Collector

This block gathers the overhead events that an upstream E3 receive framer reports once per frame and turns them into a byte-wide interrupt status register. Each status bit has a matching enable bit. A single active-low interrupt request is driven while any enabled status bit is set. A host reads and writes the registers through a simple synchronous register bus. Read data appears one cycle after the read strobe.

The block holds the far-end receive failure (FERF) state. It updates this state from the MA-byte FERF bit that the framer delivers with each frame strobe. A change interrupt is raised when the state is declared and again when it is cleared. The block also keeps the most recent 16-byte trail trace message. When a message arrives that differs from the stored one, the block captures it into readable byte registers and flags a trail-trace change. Status bits clear when the host reads them. An event that lands in the same cycle as the read is not lost.

Top module: `e3_rx_alarm_irq`

## Requirements
- R1: After reset the status register (0x15), the enable register (0x13) and the FERF state register (0x16) all read 0x00, and irq_n is 1.
- R2: Writing the enable register at 0x13 stores bits 6, 4, 3, 2, 1 and 0. Bits 7 and 5 always read 0, so writing 0xFF reads back 0x5F.
- R3: A read of the status register at 0x15 returns its current value. The bits that were returned as 1 are then cleared, so an immediate second read returns 0x00.
- R4: An event whose enable bit is 0 leaves its status bit at 0 and does not pull irq_n low.
- R5: A frame strobe whose FERF bit is 1 while the held FERF state is 0 declares FERF. The state becomes 1 and, when enabled, status bit 3 is set.
- R6: A frame strobe whose FERF bit is 0 while the held FERF state is 1 clears FERF. The state becomes 0 and, when enabled, status bit 3 is set.
- R7: A frame strobe whose FERF bit equals the held state causes no FERF interrupt.
- R8: Bit 0 of register 0x16 shows the current FERF state whether or not the FERF interrupt is enabled. Its other bits read 0.
- R9: irq_n is 0 exactly while at least one status bit is 1 whose enable bit is also 1. It returns to 1 once such bits are read-cleared or disabled.
- R10: If an enabled event occurs in the same cycle as a status read, its bit is 1 after the read.
- R11: A trail trace strobe carrying a 16-byte message that differs from the stored one stores it and, when enabled, sets status bit 6. Byte i (trace_msg bits 8i+7..8i) reads at address 0x1C+i, for 0x1C through 0x2B. A message equal to the stored one sets no status bit.
- R12: Status bit positions are FEBE bit 4, BIP-8 error bit 2, framing byte error bit 1 and payload type mismatch bit 0. Each is set one cycle after its one-cycle event pulse, when enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| frm_stb | input | 1 | One pulse per received frame |
| frm_ferf | input | 1 | FERF bit of the MA byte, valid with frm_stb |
| ev_febe | input | 1 | FEBE event pulse |
| ev_bip | input | 1 | BIP-8 error event pulse |
| ev_fa | input | 1 | Framing byte error event pulse |
| ev_ptm | input | 1 | Payload type mismatch event pulse |
| trace_stb | input | 1 | A complete trail trace message is presented |
| trace_msg | input | 128 | Trail trace message, byte i in bits 8i+7..8i |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The FERF path is driven with a declaring frame, a repeated frame with the same value, and a clearing frame. This separates true state changes from frames that only repeat the held value. A FERF declaration is also made with the interrupt disabled, which shows that the state register moves independently of the status bit. Each single-bit event is pulsed alone and then in pairs, which confirms bit positions and read-to-clear. One event is made to coincide with a status read, which shows that the event survives the read. Trail trace messages are sent new, repeated and changed, which separates a real message change from a re-delivery.

// File: rtl/e3_rx_alarm_irq.sv
module e3_rx_alarm_irq #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int TRACE_BYTES = 16,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 8'h13,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h15,
  parameter logic [ADDR_W-1:0] FERF_ADDR = 8'h16,
  parameter logic [ADDR_W-1:0] TRC_BASE  = 8'h1C
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr,
  input  logic [DATA_W-1:0]         bus_wdata,
  input  logic                      bus_rd,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic                      frm_stb,
  input  logic                      frm_ferf,
  input  logic                      ev_febe,
  input  logic                      ev_bip,
  input  logic                      ev_fa,
  input  logic                      ev_ptm,
  input  logic                      trace_stb,
  input  logic [8*TRACE_BYTES-1:0]  trace_msg,
  output logic                      irq_n
);

  localparam int TRACE_W = 8 * TRACE_BYTES;
  localparam logic [DATA_W-1:0] BIT_MASK = DATA_W'(8'h5F);

  logic [DATA_W-1:0]  enable;
  logic [DATA_W-1:0]  status;
  logic               ferf_state;
  logic [TRACE_W-1:0] trace_q;
  logic               ferf_evt;
  logic               trace_evt;
  logic [DATA_W-1:0]  events;
  logic [DATA_W-1:0]  stat_clr;
  logic [DATA_W-1:0]  rd_mux;

  assign ferf_evt  = frm_stb && (frm_ferf != ferf_state);
  assign trace_evt = trace_stb && (trace_msg != trace_q);

  assign events = DATA_W'({1'b0, trace_evt, 1'b0, ev_febe,
                           ferf_evt, ev_bip, ev_fa, ev_ptm});

  assign stat_clr = (bus_rd && bus_addr == STAT_ADDR) ? status : '0;

  assign irq_n = ~|(status & enable);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable     <= '0;
      status     <= '0;
      ferf_state <= 1'b0;
      trace_q    <= '0;
    end else begin
      if (bus_wr && bus_addr == EN_ADDR)
        enable <= bus_wdata & BIT_MASK;
      status <= (status & ~stat_clr) | (events & enable & BIT_MASK);
      if (ferf_evt)
        ferf_state <= frm_ferf;
      if (trace_evt)
        trace_q <= trace_msg;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == EN_ADDR)
      rd_mux = enable;
    else if (bus_addr == STAT_ADDR)
      rd_mux = status;
    else if (bus_addr == FERF_ADDR)
      rd_mux = DATA_W'(ferf_state);
    for (int i = 0; i < TRACE_BYTES; i++) begin
      if (int'(bus_addr) == int'(TRC_BASE) + i)
        rd_mux = DATA_W'(trace_q[8*i +: 8]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_mux;
  end

endmodule

module e3_rx_alarm_irq_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h15
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              frm_stb,
  input logic              frm_ferf,
  input logic              ev_febe,
  input logic              ev_bip,
  input logic              ev_fa,
  input logic              ev_ptm,
  input logic              trace_stb,
  input logic              irq_n,
  input logic [DATA_W-1:0] status,
  input logic [DATA_W-1:0] enable,
  input logic              ferf_state
);

  a_r9_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (status != '0));

  a_r2_unused_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] == 1'b0) && (status[5] == 1'b0) && (enable[7] == 1'b0) && (enable[5] == 1'b0));

  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == STAT_ADDR && !frm_stb && !ev_febe && !ev_bip
     && !ev_fa && !ev_ptm && !trace_stb) |=> (status == '0));

  a_r5_ferf_change_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_stb && frm_ferf != ferf_state && enable[3]) |=> (status[3] && ferf_state == $past(frm_ferf)));

  a_r7_ferf_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_stb |=> $stable(ferf_state));

  a_r10_event_survives_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == STAT_ADDR && ev_febe && enable[4]) |=> status[4]);

endmodule

bind e3_rx_alarm_irq e3_rx_alarm_irq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .frm_stb(frm_stb), .frm_ferf(frm_ferf), .ev_febe(ev_febe),
  .ev_bip(ev_bip), .ev_fa(ev_fa), .ev_ptm(ev_ptm), .trace_stb(trace_stb),
  .irq_n(irq_n), .status(status), .enable(enable), .ferf_state(ferf_state)
);

// File: tb/e3_rx_alarm_irq_test.sv
`timescale 1ns/100ps
module e3_rx_alarm_irq_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [7:0]   bus_wdata = '0;
  logic         bus_rd = 1'b0;
  logic [7:0]   bus_rdata;
  logic         frm_stb = 1'b0;
  logic         frm_ferf = 1'b0;
  logic         ev_febe = 1'b0;
  logic         ev_bip = 1'b0;
  logic         ev_fa = 1'b0;
  logic         ev_ptm = 1'b0;
  logic         trace_stb = 1'b0;
  logic [127:0] trace_msg = '0;
  logic         irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic rd_seen = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  e3_rx_alarm_irq uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .frm_stb(frm_stb), .frm_ferf(frm_ferf), .ev_febe(ev_febe),
    .ev_bip(ev_bip), .ev_fa(ev_fa), .ev_ptm(ev_ptm),
    .trace_stb(trace_stb), .trace_msg(trace_msg), .irq_n(irq_n)
  );

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: read data %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq_n !== e) begin
      errors++;
      $display("FAIL %s: irq_n %b expected %b", t, irq_n, e);
    end
  endtask

  task automatic pulse_evt(input int which);
    @(negedge clk);
    case (which)
      0: ev_ptm = 1'b1;
      1: ev_fa = 1'b1;
      2: ev_bip = 1'b1;
      default: ev_febe = 1'b1;
    endcase
    @(negedge clk);
    ev_ptm = 1'b0; ev_fa = 1'b0; ev_bip = 1'b0; ev_febe = 1'b0;
  endtask

  task automatic frame(input logic f);
    @(negedge clk);
    frm_stb = 1'b1; frm_ferf = f;
    @(negedge clk);
    frm_stb = 1'b0;
  endtask

  task automatic send_trace(input logic [127:0] m);
    @(negedge clk);
    trace_stb = 1'b1; trace_msg = m;
    @(negedge clk);
    trace_stb = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] m1;
    logic [127:0] m2;
    for (int i = 0; i < 16; i++) begin
      m1[8*i +: 8] = 8'hA0 + 8'(i);
      m2[8*i +: 8] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_irq(1'b1, "R1");
    rd(8'h13, 8'h00, "R1 enable");
    rd(8'h15, 8'h00, "R1 status");
    rd(8'h16, 8'h00, "R1 ferf");

    // R2 enable mask
    wr(8'h13, 8'hFF);
    rd(8'h13, 8'h5F, "R2");
    wr(8'h13, 8'h00);

    // R4 disabled event ignored
    pulse_evt(3);
    chk_irq(1'b1, "R4");
    rd(8'h15, 8'h00, "R4");

    // R12 bit positions, R9 irq release
    wr(8'h13, 8'h5F);
    pulse_evt(3); chk_irq(1'b0, "R9 febe"); rd(8'h15, 8'h10, "R12 febe");
    chk_irq(1'b1, "R9 released");
    pulse_evt(2); rd(8'h15, 8'h04, "R12 bip");
    pulse_evt(1); rd(8'h15, 8'h02, "R12 fa");
    pulse_evt(0); rd(8'h15, 8'h01, "R12 ptm");

    // R3 read clear
    pulse_evt(2); pulse_evt(1);
    rd(8'h15, 8'h06, "R3 first");
    rd(8'h15, 8'h00, "R3 second");

    // R5 declare
    frame(1'b1);
    chk_irq(1'b0, "R5 irq");
    rd(8'h16, 8'h01, "R5 state");
    rd(8'h15, 8'h08, "R5 status");
    // R7 repeat
    frame(1'b1);
    rd(8'h15, 8'h00, "R7");
    chk_irq(1'b1, "R7 irq");
    // R6 clear
    frame(1'b0);
    rd(8'h15, 8'h08, "R6 status");
    rd(8'h16, 8'h00, "R6 state");

    // R8 state visible when disabled
    wr(8'h13, 8'h00);
    frame(1'b1);
    chk_irq(1'b1, "R8 irq");
    rd(8'h16, 8'h01, "R8 state");
    rd(8'h15, 8'h00, "R8 status");
    wr(8'h13, 8'h5F);
    frame(1'b0);
    rd(8'h15, 8'h08, "R8 clear");

    // R9 disable masks irq
    pulse_evt(0);
    chk_irq(1'b0, "R9 set");
    wr(8'h13, 8'h00);
    chk_irq(1'b1, "R9 masked");
    rd(8'h15, 8'h01, "R9 status");
    wr(8'h13, 8'h5F);

    // R10 event during read
    pulse_evt(3);
    @(negedge clk);
    bus_addr = 8'h15; bus_rd = 1'b1; ev_febe = 1'b1;
    exp_q.push_back(8'h10); tag_q.push_back("R10 first");
    @(negedge clk);
    bus_rd = 1'b0; ev_febe = 1'b0;
    rd(8'h15, 8'h10, "R10 kept");
    rd(8'h15, 8'h00, "R10 cleared");

    // R11 trail trace
    send_trace(m1);
    rd(8'h15, 8'h40, "R11 change");
    for (int i = 0; i < 16; i++)
      rd(8'h1C + 8'(i), m1[8*i +: 8], "R11 byte");
    send_trace(m1);
    rd(8'h15, 8'h00, "R11 same msg");
    send_trace(m2);
    rd(8'h15, 8'h40, "R11 second change");
    rd(8'h1C, m2[7:0], "R11 first byte");
    rd(8'h2B, m2[127:120], "R11 last byte");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule